// File: doc/BRIEF.md
# Banked Host Register Window with Buffer Pointer

This block gives a byte-wide host bus access to a small network controller's register set through a 16-byte address window. A bank-select register picks which of four register banks the lower fourteen offsets reach. Two offsets are decoded the same way in every bank: one holds the bank select and the other returns a fixed signature byte.

One bank holds a 16-bit buffer pointer and a four-byte data port. Each data-port access turns into a single byte access on the packet-memory port. Each buffer in that memory is 2048 bytes. The pointer's top bit chooses the buffer. When it is set, the access goes to the receive-queue head. When it is clear, the access goes to the packet number the host selected.

The pointer has two modes. In auto-increment mode, every data-port access steps the 11-bit offset field and leaves the control bits untouched. In fixed mode, the low address bits are added to the pointer offset and the pointer does not change. The allocation unit and the receive path sit outside this block: the queue head, the host packet number and the buffer-in-use mask arrive as inputs.

Top module: `bank_window`

## Requirements
- R1: Only the four address bits exist. Offset 14 is the bank select in every bank. A write stores data bits 1:0, and a read returns the bank number in bits 1:0 with zeros above.
- R2: Offset 15 reads 0x33 in every bank.
- R3: Pointer bit 15 selects the buffer for data-port accesses: 1 selects `rxq_head` and 0 selects `pkt_num`.
- R4: With pointer bit 14 set, each data-port access (bank 2, offsets 8 to 11, read or write) uses pointer bits 10:0 as the byte offset. After the access, bits 10:0 increment modulo 2048 and bits 15:11 keep their value.
- R5: With pointer bit 14 clear, the byte offset is pointer bits 10:0 plus address bits 1:0, modulo 2048, and the pointer does not change.
- R6: Bank 2 offset 6 is the pointer low byte and offset 7 is the pointer high byte. The high byte reads back ANDed with 0xF7.
- R7: Bank 0 offset 8 reads the buffer count (4 by default). Offset 9 reads the number of set bits in `inuse`.
- R8: After reset the bank is 0 and the pointer is 0. The configuration register (bank 1, offsets 0/1) is 0xA0B1. The control register (bank 1, offsets 12/13) is 0x1210. The early-receive threshold (bank 3, offset 12, 5 bits) is 0x1F. The transmit-control, receive-control and general-purpose registers are 0.
- R9: A write to bank 0 offset 5 (receive-control high byte) with data bit 7 set puts every register, including the bank select and the pointer, back to its reset value from the next cycle.
- R10: A write to the control register low byte (bank 1 offset 12) stores data bits 1:0 as zero.
- R11: Offsets not defined in a requirement read 0, and writes to them change no register.
- R12: A data-port write drives `mem_en`, `mem_we` and `mem_wdata`. A data-port read returns `mem_rdata` on `host_rdata` in the same cycle.
- R13: Transmit control (bank 0, offsets 0/1), receive control (bank 0, offsets 4/5) and general purpose (bank 1, offsets 10/11) are plain 16-bit read/write registers, with the low byte at the even offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Byte offset in the window |
| host_wr | input | 1 | Write strobe, one cycle per byte |
| host_rd | input | 1 | Read strobe, one cycle per byte |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid while host_rd is high |
| mem_en | output | 1 | Packet-memory access this cycle |
| mem_we | output | 1 | Packet-memory write |
| mem_buf | output | BUF_W | Buffer index of the access |
| mem_off | output | 11 | Byte offset inside the buffer |
| mem_wdata | output | 8 | Packet-memory write data |
| mem_rdata | input | 8 | Packet-memory read data, combinational |
| rxq_head | input | BUF_W | Buffer at the head of the receive queue |
| pkt_num | input | BUF_W | Buffer selected by the host |
| inuse | input | NUM_BUFS | One bit per allocated buffer |

## Verification
The hardest case to reach is the offset wrap. It needs a pointer loaded near the end of a buffer, with its control bits set, followed by several data-port accesses. The stimulus loads the pointer to 0x7FFE and writes three bytes. It then checks that they land at offsets 0x7FE, 0x7FF and 0x000 of the selected buffer, and that the control bits read back unchanged. A fixed-mode access at offset 0x7FF with address bit 0 set exercises the additive wrap. A soft reset is issued only after every register has been moved away from its reset value, so the return to reset can be observed.

// File: rtl/bank_window_pkg.sv
package bank_window_pkg;

    localparam int PTR_W = 16;
    localparam int OFF_W = 11;

    localparam logic [15:0] CFG_RST   = 16'hA0B1;
    localparam logic [15:0] CTL_RST   = 16'h1210;
    localparam logic [4:0]  ERX_RST   = 5'h1F;
    localparam logic [7:0]  SIG_BYTE  = 8'h33;
    localparam logic [7:0]  PTRH_MASK = 8'hF7;

    localparam logic [3:0] OFF_BANK  = 4'd14;
    localparam logic [3:0] OFF_SIG   = 4'd15;
    localparam logic [1:0] BANK_DATA = 2'd2;

    typedef struct packed {
        logic [1:0]  bank;
        logic [15:0] txc;
        logic [15:0] rxc;
        logic [15:0] cfg;
        logic [15:0] gp;
        logic [15:0] ctl;
        logic [4:0]  erx;
    } regs_t;

    function automatic regs_t regs_reset();
        regs_t r;
        r.bank = 2'd0;
        r.txc  = 16'h0000;
        r.rxc  = 16'h0000;
        r.cfg  = CFG_RST;
        r.gp   = 16'h0000;
        r.ctl  = CTL_RST;
        r.erx  = ERX_RST;
        return r;
    endfunction

endpackage

// File: rtl/bank_window_regs.sv
module bank_window_regs
    import bank_window_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic       soft_rst_i,
    input  logic [3:0] off_i,
    input  logic [7:0] wdata_i,
    output regs_t      regs_o
);

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (soft_rst_i) begin
            r_d = regs_reset();
        end else if (wr_i) begin
            if (off_i == OFF_BANK) begin
                r_d.bank = wdata_i[1:0];
            end else begin
                case (r_q.bank)
                    2'd0: begin
                        case (off_i)
                            4'd0: r_d.txc[7:0]  = wdata_i;
                            4'd1: r_d.txc[15:8] = wdata_i;
                            4'd4: r_d.rxc[7:0]  = wdata_i;
                            4'd5: r_d.rxc[15:8] = wdata_i;
                            default: ;
                        endcase
                    end
                    2'd1: begin
                        case (off_i)
                            4'd0:  r_d.cfg[7:0]  = wdata_i;
                            4'd1:  r_d.cfg[15:8] = wdata_i;
                            4'd10: r_d.gp[7:0]   = wdata_i;
                            4'd11: r_d.gp[15:8]  = wdata_i;
                            4'd12: r_d.ctl[7:0]  = {wdata_i[7:2], 2'b00};
                            4'd13: r_d.ctl[15:8] = wdata_i;
                            default: ;
                        endcase
                    end
                    2'd3: begin
                        if (off_i == 4'd12) r_d.erx = wdata_i[4:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= regs_reset();
        else        r_q <= r_d;
    end

    assign regs_o = r_q;

    AST_CTL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ctl[1:0] == 2'b00); // R10

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && r_q.bank == 2'd0 && off_i == 4'd5 && wdata_i[7])
        |=> (r_q.bank == 2'd0 && r_q.cfg == CFG_RST && r_q.ctl == CTL_RST
             && r_q.erx == ERX_RST && r_q.rxc == 16'h0000)); // R9

endmodule

// File: rtl/bank_window_ptr.sv
module bank_window_ptr
    import bank_window_pkg::*;
#(
    parameter int BUF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic [7:0]       wdata_i,
    input  logic             acc_i,
    input  logic [1:0]       addr_lo_i,
    input  logic [BUF_W-1:0] rxq_head_i,
    input  logic [BUF_W-1:0] pkt_num_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic [BUF_W-1:0] buf_o,
    output logic [OFF_W-1:0] off_o
);

    localparam int SEL_BIT  = PTR_W - 1;
    localparam int AUTO_BIT = PTR_W - 2;

    logic [PTR_W-1:0] ptr_d, ptr_q;
    logic             auto_inc;

    assign auto_inc = ptr_q[AUTO_BIT];

    always_comb begin
        ptr_d = ptr_q;
        if (soft_rst_i) begin
            ptr_d = '0;
        end else if (wr_lo_i) begin
            ptr_d[7:0] = wdata_i;
        end else if (wr_hi_i) begin
            ptr_d[15:8] = wdata_i;
        end else if (acc_i && auto_inc) begin
            ptr_d[OFF_W-1:0] = ptr_q[OFF_W-1:0] + OFF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign buf_o = ptr_q[SEL_BIT] ? rxq_head_i : pkt_num_i;
    assign off_o = auto_inc ? ptr_q[OFF_W-1:0]
                            : ptr_q[OFF_W-1:0] + OFF_W'(addr_lo_i);
    assign ptr_o = ptr_q;

    AST_AUTOINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && auto_inc && !soft_rst_i)
        |=> (ptr_q[OFF_W-1:0] == $past(ptr_q[OFF_W-1:0]) + OFF_W'(1))
            && (ptr_q[PTR_W-1:OFF_W] == $past(ptr_q[PTR_W-1:OFF_W]))); // R4

    AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !auto_inc && !soft_rst_i && !wr_lo_i && !wr_hi_i)
        |=> (ptr_q == $past(ptr_q))); // R5

endmodule

// File: rtl/bank_window_rdmux.sv
module bank_window_rdmux
    import bank_window_pkg::*;
#(
    parameter int NUM_BUFS = 4
) (
    input  logic [3:0]          off_i,
    input  regs_t               regs_i,
    input  logic [PTR_W-1:0]    ptr_i,
    input  logic [NUM_BUFS-1:0] inuse_i,
    input  logic [7:0]          mem_rdata_i,
    output logic [7:0]          rdata_o
);

    localparam int CNT_W = $clog2(NUM_BUFS + 1);

    logic [CNT_W-1:0] used_cnt;

    always_comb begin
        used_cnt = '0;
        for (int i = 0; i < NUM_BUFS; i++) begin
            used_cnt = used_cnt + CNT_W'(inuse_i[i]);
        end
    end

    always_comb begin
        rdata_o = 8'h00;
        if (off_i == OFF_BANK) begin
            rdata_o = {6'b0, regs_i.bank};
        end else if (off_i == OFF_SIG) begin
            rdata_o = SIG_BYTE;
        end else begin
            case (regs_i.bank)
                2'd0: begin
                    case (off_i)
                        4'd0: rdata_o = regs_i.txc[7:0];
                        4'd1: rdata_o = regs_i.txc[15:8];
                        4'd4: rdata_o = regs_i.rxc[7:0];
                        4'd5: rdata_o = regs_i.rxc[15:8];
                        4'd8: rdata_o = 8'(NUM_BUFS);
                        4'd9: rdata_o = 8'(used_cnt);
                        default: ;
                    endcase
                end
                2'd1: begin
                    case (off_i)
                        4'd0:  rdata_o = regs_i.cfg[7:0];
                        4'd1:  rdata_o = regs_i.cfg[15:8];
                        4'd10: rdata_o = regs_i.gp[7:0];
                        4'd11: rdata_o = regs_i.gp[15:8];
                        4'd12: rdata_o = regs_i.ctl[7:0];
                        4'd13: rdata_o = regs_i.ctl[15:8];
                        default: ;
                    endcase
                end
                2'd2: begin
                    case (off_i)
                        4'd6:  rdata_o = ptr_i[7:0];
                        4'd7:  rdata_o = ptr_i[15:8] & PTRH_MASK;
                        4'd8, 4'd9, 4'd10, 4'd11: rdata_o = mem_rdata_i;
                        default: ;
                    endcase
                end
                default: begin
                    if (off_i == 4'd12) rdata_o = {3'b0, regs_i.erx};
                end
            endcase
        end
    end

endmodule

// File: rtl/bank_window.sv
module bank_window
    import bank_window_pkg::*;
#(
    parameter int NUM_BUFS = 4,
    localparam int BUF_W = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          host_addr,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [7:0]          host_wdata,
    output logic [7:0]          host_rdata,
    output logic                mem_en,
    output logic                mem_we,
    output logic [BUF_W-1:0]    mem_buf,
    output logic [10:0]         mem_off,
    output logic [7:0]          mem_wdata,
    input  logic [7:0]          mem_rdata,
    input  logic [BUF_W-1:0]    rxq_head,
    input  logic [BUF_W-1:0]    pkt_num,
    input  logic [NUM_BUFS-1:0] inuse
);

    regs_t            regs;
    logic [PTR_W-1:0] ptr;
    logic             in_data_bank;
    logic             data_acc;
    logic             soft_rst;
    logic             ptr_wr_lo;
    logic             ptr_wr_hi;

    assign in_data_bank = (regs.bank == BANK_DATA);
    assign data_acc  = (host_wr || host_rd) && in_data_bank && (host_addr[3:2] == 2'b10);
    assign soft_rst  = host_wr && (regs.bank == 2'd0) && (host_addr == 4'd5) && host_wdata[7];
    assign ptr_wr_lo = host_wr && in_data_bank && (host_addr == 4'd6);
    assign ptr_wr_hi = host_wr && in_data_bank && (host_addr == 4'd7);

    bank_window_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (host_wr),
        .soft_rst_i (soft_rst),
        .off_i      (host_addr),
        .wdata_i    (host_wdata),
        .regs_o     (regs)
    );

    bank_window_ptr #(.BUF_W(BUF_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst),
        .wr_lo_i    (ptr_wr_lo),
        .wr_hi_i    (ptr_wr_hi),
        .wdata_i    (host_wdata),
        .acc_i      (data_acc),
        .addr_lo_i  (host_addr[1:0]),
        .rxq_head_i (rxq_head),
        .pkt_num_i  (pkt_num),
        .ptr_o      (ptr),
        .buf_o      (mem_buf),
        .off_o      (mem_off)
    );

    bank_window_rdmux #(.NUM_BUFS(NUM_BUFS)) u_rdmux (
        .off_i       (host_addr),
        .regs_i      (regs),
        .ptr_i       (ptr),
        .inuse_i     (inuse),
        .mem_rdata_i (mem_rdata),
        .rdata_o     (host_rdata)
    );

    assign mem_en    = data_acc;
    assign mem_we    = data_acc && host_wr;
    assign mem_wdata = host_wdata;

    AST_SIG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == OFF_SIG) |-> (host_rdata == SIG_BYTE)); // R2

endmodule

// File: tb/bank_window_tb.sv
module bank_window_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        mem_en, mem_we;
    logic [1:0]  mem_buf;
    logic [10:0] mem_off;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic [1:0]  rxq_head = 2'd1;
    logic [1:0]  pkt_num = 2'd2;
    logic [3:0]  inuse = 4'b1011;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    logic [7:0] mem [0:3][0:2047];

    always #10 clk = ~clk;

    bank_window u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_buf(mem_buf), .mem_off(mem_off),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rxq_head(rxq_head),
        .pkt_num(pkt_num), .inuse(inuse)
    );

    assign mem_rdata = mem[mem_buf][mem_off];

    always @(posedge clk) begin
        if (mem_en && mem_we) mem[mem_buf][mem_off] <= mem_wdata;
    end

    // monitor: pops expected read data and compares before the next edge
    always begin
        @(negedge clk);
        #5;
        if (host_rd) begin
            checks++;
            if (sb.size() == 0) begin
                failures++;
                $display("FAIL unexpected read actual=%h expected=none", host_rdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (host_rdata !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, host_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        sb.push_back('{exp: e, tag: tag});
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] e, input string tag);
        checks++;
        if (act !== e) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        mem[1][16] <= 8'h5C; mem[1][17] <= 8'h6D;
        mem[2][32] <= 8'hB0; mem[2][33] <= 8'hB1;
        mem[2][34] <= 8'hB2; mem[2][35] <= 8'hB3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state, bank 0
        rd(4'd14, 8'h00, "R8 bank reset");
        rd(4'd15, 8'h33, "R2 signature bank0");
        rd(4'd8,  8'h04, "R7 pool size");
        rd(4'd9,  8'h03, "R7 in-use count");
        rd(4'd0,  8'h00, "R8 txc reset");
        rd(4'd4,  8'h00, "R8 rxc reset");
        wr(4'd0, 8'h3C); wr(4'd1, 8'h96);
        rd(4'd0,  8'h3C, "R13 txc low");
        rd(4'd1,  8'h96, "R13 txc high");
        wr(4'd2, 8'h77);
        rd(4'd2,  8'h00, "R11 undefined bank0");

        // bank 1
        wr(4'd14, 8'h01);
        rd(4'd14, 8'h01, "R1 bank readback");
        rd(4'd0,  8'hB1, "R8 cfg low");
        rd(4'd1,  8'hA0, "R8 cfg high");
        rd(4'd12, 8'h10, "R8 ctl low");
        rd(4'd13, 8'h12, "R8 ctl high");
        rd(4'd15, 8'h33, "R2 signature bank1");
        wr(4'd12, 8'hFF);
        rd(4'd12, 8'hFC, "R10 ctl low bits forced");
        wr(4'd13, 8'h08);
        rd(4'd13, 8'h08, "R13 ctl high");
        wr(4'd10, 8'h5A); wr(4'd11, 8'hC3);
        rd(4'd10, 8'h5A, "R13 gp low");
        rd(4'd11, 8'hC3, "R13 gp high");
        wr(4'd0, 8'h11);
        rd(4'd0,  8'h11, "R13 cfg write");
        wr(4'd4, 8'h77);
        rd(4'd4,  8'h00, "R11 undefined bank1");

        // bank 3
        wr(4'd14, 8'h03);
        rd(4'd12, 8'h1F, "R8 erx reset");
        wr(4'd12, 8'hE5);
        rd(4'd12, 8'h05, "R8 erx 5 bits");
        wr(4'd13, 8'h55);
        rd(4'd13, 8'h00, "R11 undefined bank3");
        rd(4'd0,  8'h00, "R11 undefined bank3 low");

        // bank 2 via upper data bits ignored
        wr(4'd14, 8'hFE);
        rd(4'd14, 8'h02, "R1 bank uses bits 1:0");
        wr(4'd6, 8'h34); wr(4'd7, 8'hFF);
        rd(4'd6,  8'h34, "R6 ptr low");
        rd(4'd7,  8'hF7, "R6 ptr high masked");

        // auto-increment with wrap, host packet buffer
        wr(4'd6, 8'hFE); wr(4'd7, 8'h7F);
        wr(4'd8, 8'hA1); wr(4'd9, 8'hA2); wr(4'd10, 8'hA3);
        chk(mem[2][11'h7FE], 8'hA1, "R4 write at 7FE");
        chk(mem[2][11'h7FF], 8'hA2, "R4 write at 7FF");
        chk(mem[2][0],       8'hA3, "R4 wrap to 000");
        rd(4'd6,  8'h01, "R4 offset after wrap");
        rd(4'd7,  8'h70, "R4 control bits kept");

        // auto-increment from receive head
        wr(4'd6, 8'h10); wr(4'd7, 8'hC0);
        rd(4'd8,  8'h5C, "R3 rx head buffer");
        rd(4'd11, 8'h6D, "R4 ignores addr bits");
        rd(4'd6,  8'h12, "R4 reads advance pointer");

        // fixed mode
        wr(4'd7, 8'h00); wr(4'd6, 8'h20);
        rd(4'd8,  8'hB0, "R5 offset +0");
        rd(4'd9,  8'hB1, "R5 offset +1");
        rd(4'd10, 8'hB2, "R5 offset +2");
        rd(4'd11, 8'hB3, "R5 offset +3 R12");
        rd(4'd6,  8'h20, "R5 pointer unchanged");
        wr(4'd7, 8'h07); wr(4'd6, 8'hFF);
        wr(4'd9, 8'hEE);
        chk(mem[2][0], 8'hEE, "R5 additive wrap R12");
        rd(4'd7,  8'h07, "R5 pointer high unchanged");
        wr(4'd7, 8'h80); wr(4'd6, 8'h11);
        rd(4'd8,  8'h6D, "R3 select bit fixed mode");

        // soft reset
        wr(4'd14, 8'h00);
        inuse = 4'b1111;
        rd(4'd9,  8'h04, "R7 count all used");
        wr(4'd4, 8'h01);
        wr(4'd5, 8'h80);
        rd(4'd4,  8'h00, "R9 rxc cleared");
        rd(4'd5,  8'h00, "R9 rxc high cleared");
        rd(4'd0,  8'h00, "R9 txc cleared");
        wr(4'd14, 8'h01);
        rd(4'd0,  8'hB1, "R9 cfg restored");
        rd(4'd10, 8'h00, "R9 gp cleared");
        rd(4'd12, 8'h10, "R9 ctl restored");
        wr(4'd14, 8'h03);
        rd(4'd12, 8'h1F, "R9 erx restored");
        wr(4'd14, 8'h02);
        rd(4'd6,  8'h00, "R9 ptr low cleared");
        rd(4'd7,  8'h00, "R9 ptr high cleared");

        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL scoreboard drain actual=%0d expected=0", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule